// File: doc/BRIEF.md
# Page-Mode Burst ROM Bus Interface

This block drives an external memory bus with two chip-select areas. Either area can be set up as page-mode ROM space. A CPU read to such an area starts with a longer initial access. The block then reads further consecutive words from the same page. Each of these words takes a short, programmable number of cycles. Writes, and any access to an area whose burst enable is clear, take a single fixed-length basic cycle.

A request is accepted in any cycle where the block is idle and `req_valid` is high. The block latches the target area's settings at that moment. While it works, it holds `busy` high and keeps the area's chip select low. It ends a burst for one of three reasons: the word limit is reached, the next address would start a new page, or the CPU drops `req_cont`. After the last word, chip select rises for at least one cycle before the next access begins. Every word read produces a one-cycle `rd_valid` pulse with the captured data.

Top module: `brom_bus_if`

## Requirements
- R1: During and after synchronous reset, with no request: `busy`=0, `ext_cs_n`=2'b11, `ext_rd_n`=1, `ext_wr_n`=1, `rd_valid`=0.
- R2: A read to an area whose burst enable bit is 1 holds chip select and read strobe low for INIT_CYC cycles (default 3) for the first word. Each further word of the burst then takes v+1 cycles, where v is that area's 3-bit cycle field, giving a range of 1 to 8 cycles.
- R3: The area's 2-bit length field caps the number of words in one burst: 00 gives 4, 01 gives 8, 10 gives 16 and 11 gives 32.
- R4: A page is the word limit times the bus width in bytes, aligned to its own size. A burst stops after the word whose successor address is a multiple of the page size.
- R5: A burst stops after the current word when `req_cont` is 0 at that word's last cycle.
- R6: Within a burst the address rises by 1 per word when the area's width bit is 0 (8-bit), and by 2 when it is 1 (16-bit). Chip select stays low across all words of the burst.
- R7: Writes, and reads to an area whose burst enable is 0, make a single access of BASIC_CYC cycles (default 2). A write drives `ext_wr_n` low instead of `ext_rd_n`, and drives `ext_dout` with the request data.
- R8: Chip select bit i goes low only for requests with `req_area`=i. The area's settings are taken when the request is accepted. Settings of the other area, or changes made later, have no effect on that access.
- R9: `rd_valid` pulses for one cycle after each read word's last cycle, with `rd_data` equal to `ext_din` sampled in that last cycle. In an 8-bit area the result is {8'h00, din[7:0]}. A basic byte read (`req_size`=0) from a 16-bit area returns din[15:8] for an even address and din[7:0] for an odd one, zero-extended. Any other 16-bit read returns din[15:0].
- R10: `busy` is high from the cycle after acceptance until the last access finishes. Requests that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = 16-bit word |
| req_area | input | 1 | Target area (0 or 1) |
| req_addr | input | ADDR_W | Start byte address |
| req_wdata | input | 16 | Write data |
| req_cont | input | 1 | CPU keeps asking for sequential words |
| cfg_burst_en | input | 2 | Per-area burst enable, bit i for area i |
| cfg_blen | input | 4 | Per-area length code, bits [2i+1:2i] |
| cfg_bcyc | input | 6 | Per-area burst cycle field, bits [3i+2:3i] |
| cfg_wide | input | 2 | Per-area width, 1 = 16-bit |
| ext_din | input | 16 | External read data |
| ext_addr | output | ADDR_W | External address |
| ext_cs_n | output | 2 | Active-low chip selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_dout | output | 16 | External write data |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | One pulse per word read |
| busy | output | 1 | Access in progress |

## Verification
Three reasons can end a burst: the word limit, the page-boundary stop and the drop of `req_cont`. They can all be judged at the same word's last cycle. The bench makes them coincide by starting a burst at a page-aligned address, where the limit and the boundary fall on the same word. It also starts a burst just short of the boundary, so that the page stop comes well before the limit. In a further run it drops `req_cont` at a known edge. A behavioural model, run every clock, predicts the strobes, addresses and data pulses. Word and busy-cycle counts computed by hand confirm which reason ended each burst.

// File: rtl/brom_pkg.sv
package brom_pkg;

    localparam int NUM_AREAS = 2;
    localparam int DATA_W    = 16;

    typedef struct packed {
        logic       burst_en;
        logic [1:0] blen;
        logic [2:0] bcyc;
        logic       wide;
    } area_cfg_t;

    typedef struct packed {
        logic      area;
        logic      write;
        logic      size;
        logic      burst;
        area_cfg_t cfg;
    } access_t;

    // words allowed in one burst for a length code
    function automatic logic [5:0] blen_words(input logic [1:0] code);
        return 6'd4 << code;
    endfunction

    // next address starts a fresh page
    function automatic logic page_wrap(input logic [5:0] lo,
                                       input logic [1:0] code,
                                       input logic       wide);
        logic [6:0] bytes;
        bytes = {1'b0, blen_words(code)} << wide;
        return (lo & 6'(bytes - 7'd1)) == 6'd0;
    endfunction

endpackage

// File: rtl/brom_cfg_sel.sv
module brom_cfg_sel
    import brom_pkg::*;
(
    input  logic [NUM_AREAS-1:0]   cfg_burst_en,
    input  logic [2*NUM_AREAS-1:0] cfg_blen,
    input  logic [3*NUM_AREAS-1:0] cfg_bcyc,
    input  logic [NUM_AREAS-1:0]   cfg_wide,
    input  logic                   area,
    output area_cfg_t              cfg
);
    area_cfg_t table_q [NUM_AREAS];

    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
        assign table_q[i].burst_en = cfg_burst_en[i];
        assign table_q[i].blen     = cfg_blen[2*i +: 2];
        assign table_q[i].bcyc     = cfg_bcyc[3*i +: 3];
        assign table_q[i].wide     = cfg_wide[i];
    end

    assign cfg = table_q[area];
endmodule

// File: rtl/brom_seq.sv
module brom_seq #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] start_cyc,
    input  logic             burst,
    input  logic             cont_req,
    input  logic             wrap,
    input  logic [5:0]       limit,
    input  logic [2:0]       bcyc,
    output logic             active,
    output logic             last,
    output logic             advance
);
    logic [CNT_W-1:0] cnt_q;
    logic [5:0]       words_q;
    logic             more;

    assign last    = active && (cnt_q == CNT_W'(1));
    assign more    = burst && cont_req && !wrap && ((words_q + 6'd1) < limit);
    assign advance = last && more;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cnt_q   <= '0;
            words_q <= '0;
        end else if (start) begin
            active  <= 1'b1;
            cnt_q   <= start_cyc;
            words_q <= '0;
        end else if (active) begin
            if (last) begin
                if (more) begin
                    cnt_q   <= CNT_W'(bcyc) + CNT_W'(1);
                    words_q <= words_q + 6'd1;
                end else begin
                    active  <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/brom_addr_gen.sv
module brom_addr_gen
    import brom_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    input  logic              wide,
    input  logic [1:0]        blen,
    output logic [ADDR_W-1:0] addr,
    output logic              wrap
);
    logic [ADDR_W-1:0] nxt;

    assign nxt  = addr + (wide ? ADDR_W'(2) : ADDR_W'(1));
    assign wrap = page_wrap(nxt[5:0], blen, wide);

    always_ff @(posedge clk) begin
        if (rst)          addr <= '0;
        else if (load)    addr <= load_addr;
        else if (advance) addr <= nxt;
    end
endmodule

// File: rtl/brom_lane.sv
module brom_lane
    import brom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    input  logic              wide,
    input  logic              byte_sel,
    input  logic              odd,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0] picked;

    always_comb begin
        if (!wide)         picked = {8'h00, din[7:0]};
        else if (byte_sel) picked = odd ? {8'h00, din[7:0]} : {8'h00, din[15:8]};
        else               picked = din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= picked;
        end
    end
endmodule

// File: rtl/brom_bus_if.sv
module brom_bus_if
    import brom_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int INIT_CYC  = 3,
    parameter int BASIC_CYC = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic                   req_size,
    input  logic                   req_area,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic                   req_cont,
    input  logic [NUM_AREAS-1:0]   cfg_burst_en,
    input  logic [2*NUM_AREAS-1:0] cfg_blen,
    input  logic [3*NUM_AREAS-1:0] cfg_bcyc,
    input  logic [NUM_AREAS-1:0]   cfg_wide,
    input  logic [DATA_W-1:0]      ext_din,
    output logic [ADDR_W-1:0]      ext_addr,
    output logic [NUM_AREAS-1:0]   ext_cs_n,
    output logic                   ext_rd_n,
    output logic                   ext_wr_n,
    output logic [DATA_W-1:0]      ext_dout,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   rd_valid,
    output logic                   busy
);
    localparam int MAX_A   = (INIT_CYC > BASIC_CYC) ? INIT_CYC : BASIC_CYC;
    localparam int MAX_CYC = (MAX_A > 8) ? MAX_A : 8;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    area_cfg_t         new_cfg;
    access_t           cur_q;
    logic [DATA_W-1:0] wdata_q;
    logic              active, last, advance, wrap, start, new_burst;
    logic [CNT_W-1:0]  start_cyc;

    assign start     = req_valid && !active;
    assign new_burst = new_cfg.burst_en && !req_write;
    assign start_cyc = new_burst ? CNT_W'(INIT_CYC) : CNT_W'(BASIC_CYC);

    brom_cfg_sel u_cfg (
        .cfg_burst_en (cfg_burst_en),
        .cfg_blen     (cfg_blen),
        .cfg_bcyc     (cfg_bcyc),
        .cfg_wide     (cfg_wide),
        .area         (req_area),
        .cfg          (new_cfg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            wdata_q <= '0;
        end else if (start) begin
            cur_q   <= '{area: req_area, write: req_write, size: req_size,
                         burst: new_burst, cfg: new_cfg};
            wdata_q <= req_wdata;
        end
    end

    brom_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_cyc (start_cyc),
        .burst     (cur_q.burst),
        .cont_req  (req_cont),
        .wrap      (wrap),
        .limit     (blen_words(cur_q.cfg.blen)),
        .bcyc      (cur_q.cfg.bcyc),
        .active    (active),
        .last      (last),
        .advance   (advance)
    );

    brom_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_addr (req_addr),
        .advance   (advance),
        .wide      (cur_q.cfg.wide),
        .blen      (cur_q.cfg.blen),
        .addr      (ext_addr),
        .wrap      (wrap)
    );

    brom_lane u_lane (
        .clk      (clk),
        .rst      (rst),
        .capture  (last && !cur_q.write),
        .din      (ext_din),
        .wide     (cur_q.cfg.wide),
        .byte_sel (!cur_q.size && !cur_q.burst),
        .odd      (ext_addr[0]),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_cs
        assign ext_cs_n[i] = !(active && (cur_q.area == 1'(i)));
    end

    assign ext_rd_n = !(active && !cur_q.write);
    assign ext_wr_n = !(active && cur_q.write);
    assign ext_dout = wdata_q;
    assign busy     = active;
endmodule

// File: rtl/brom_chk.sv
module brom_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic [1:0]        ext_cs_n,
    input logic              ext_rd_n,
    input logic              ext_wr_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              rd_valid
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ext_cs_n));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!ext_rd_n && !ext_wr_n));

    // R9
    valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!ext_rd_n));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext_rd_n && $past(!ext_rd_n) && (ext_addr != $past(ext_addr)))
        |-> ((ext_addr == $past(ext_addr) + ONE) || (ext_addr == $past(ext_addr) + TWO)));

    // R6
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext_rd_n && $past(!ext_rd_n)) |-> $stable(ext_cs_n));

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);
endmodule

bind brom_bus_if brom_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .ext_cs_n  (ext_cs_n),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n),
    .ext_addr  (ext_addr),
    .rd_valid  (rd_valid)
);

// File: tb/sim_brom_bus_if.sv
module sim_brom_bus_if;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 0, req_write = 0, req_size = 1, req_area = 0, req_cont = 1;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    cfg_burst_en = 2'b00, cfg_wide = 2'b11;
    logic [3:0]    cfg_blen = '0;
    logic [5:0]    cfg_bcyc = '0;
    logic [15:0]   ext_din;
    logic [AW-1:0] ext_addr;
    logic [1:0]    ext_cs_n;
    logic          ext_rd_n, ext_wr_n, rd_valid, busy;
    logic [15:0]   ext_dout, rd_data;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    brom_bus_if #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_area(req_area), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_cont(req_cont), .cfg_burst_en(cfg_burst_en),
        .cfg_blen(cfg_blen), .cfg_bcyc(cfg_bcyc), .cfg_wide(cfg_wide),
        .ext_din(ext_din), .ext_addr(ext_addr), .ext_cs_n(ext_cs_n),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_dout(ext_dout),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
    );

    function automatic int rom_b(input int a);
        return (a * 7 + (a >> 8) * 13 + 60) & 255;
    endfunction

    // page-mode ROM: even byte on the high lane in 16-bit mode
    always_comb begin
        int a;
        int sel;
        a   = int'(ext_addr);
        sel = ext_cs_n[1] ? 0 : 1;
        if (cfg_wide[sel]) ext_din = 16'((rom_b(a & ~1) << 8) | rom_b(a | 1));
        else               ext_din = 16'(16'hEE00 | rom_b(a));
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_act = 0, m_cnt, m_addr, m_area, m_wr, m_size, m_burst, m_wide;
    int m_limit, m_bcyc, m_words, m_wdata, e_valid = 0, e_data = 0;

    function automatic int exp_data(input int a);
        if (!m_wide) return rom_b(a);
        if (m_burst || m_size) return (rom_b(a & ~1) << 8) | rom_b(a | 1);
        return (a & 1) ? rom_b(a | 1) : rom_b(a & ~1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; e_valid = 0; e_data = 0;
        end else begin
            e_valid = 0;
            if (m_act) begin
                if (m_cnt == 1) begin
                    int step, nxt;
                    step = m_wide ? 2 : 1;
                    nxt  = m_addr + step;
                    if (!m_wr) begin e_valid = 1; e_data = exp_data(m_addr); end
                    if (m_burst && req_cont && (m_words + 1 < m_limit) &&
                        (nxt % (m_limit * step)) != 0) begin
                        m_addr = nxt; m_cnt = m_bcyc + 1; m_words++;
                    end else m_act = 0;
                end else m_cnt--;
            end else if (req_valid) begin
                m_act   = 1;
                m_area  = int'(req_area);
                m_wr    = int'(req_write);
                m_size  = int'(req_size);
                m_addr  = int'(req_addr);
                m_wdata = int'(req_wdata);
                m_burst = (cfg_burst_en[req_area] && !req_write) ? 1 : 0;
                m_wide  = int'(cfg_wide[req_area]);
                m_limit = 4 << cfg_blen[2*req_area +: 2];
                m_bcyc  = int'(cfg_bcyc[3*req_area +: 3]);
                m_words = 0;
                m_cnt   = m_burst ? 3 : 2;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int ecs;
            ecs = m_act ? (3 & ~(1 << m_area)) : 3;
            chk(busy == 1'(m_act), "R10 busy", busy, m_act);
            chk(ext_cs_n == 2'(ecs), "R8 chip select", ext_cs_n, ecs);
            chk(ext_rd_n == !(m_act && !m_wr), "R2 read strobe", ext_rd_n, !(m_act && !m_wr));
            chk(ext_wr_n == !(m_act && m_wr), "R7 write strobe", ext_wr_n, !(m_act && m_wr));
            if (m_act) chk(ext_addr == AW'(m_addr), "R6 address", ext_addr, m_addr);
            if (m_act && m_wr) chk(ext_dout == 16'(m_wdata), "R7 write data", ext_dout, m_wdata);
            chk(rd_valid == 1'(e_valid), "R9 valid pulse", rd_valid, e_valid);
            if (e_valid) chk(rd_data == 16'(e_data), "R9 read data", rd_data, e_data);
        end
    end

    task automatic run(input int area, input int wr, input int sz, input int addr,
                       output int nv, output int nb, output int ld);
        @(negedge clk);
        req_area = 1'(area); req_write = 1'(wr); req_size = 1'(sz);
        req_addr = AW'(addr); req_wdata = 16'(addr ^ 16'hA5C3); req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        nv = 0; nb = 0; ld = 0;
        forever begin
            if (rd_valid) begin nv++; ld = int'(rd_data); end
            if (!busy) break;
            nb++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R10 watchdog", 0, 1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int nv, nb, ld;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && ext_cs_n == 2'b11 && ext_rd_n && ext_wr_n && !rd_valid,
            "R1 reset outputs", {busy, ext_cs_n, ext_rd_n, ext_wr_n, rd_valid}, 6'b011110);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && ext_cs_n == 2'b11, "R1 idle after reset", {busy, ext_cs_n}, 3'b011);

        // area0: 16-bit, 4 words, 2-cycle burst words; aligned page
        cfg_burst_en = 2'b01; cfg_wide = 2'b11; cfg_blen = 4'b1100; cfg_bcyc = 6'b111_001;
        run(0, 0, 1, 'h100, nv, nb, ld);
        chk(nv == 4, "R3 limit 4 words", nv, 4);
        chk(nb == 9, "R2 initial 3 plus 3x2 cycles", nb, 9);

        // R4 page stop before limit
        run(0, 0, 1, 'h104, nv, nb, ld);
        chk(nv == 2, "R4 page boundary words", nv, 2);
        chk(nb == 5, "R4 page boundary cycles", nb, 5);

        // R6 8-bit area1, 8 words, 1-cycle burst words
        cfg_burst_en = 2'b11; cfg_wide = 2'b01; cfg_blen = 4'b0100; cfg_bcyc = 6'b000_001;
        run(1, 0, 1, 'h200, nv, nb, ld);
        chk(nv == 8, "R3 R6 8-bit limit 8 words", nv, 8);
        chk(nb == 10, "R2 1-cycle burst words", nb, 10);
        chk(ld == rom_b('h207), "R6 last byte address step 1", ld, rom_b('h207));

        // 32-word limit, 8-cycle words
        cfg_wide = 2'b11; cfg_blen = 4'b1100; cfg_bcyc = 6'b111_001;
        run(1, 0, 1, 'h40, nv, nb, ld);
        chk(nv == 32, "R3 limit 32 words", nv, 32);
        chk(nb == 251, "R2 8-cycle burst words", nb, 251);
        run(1, 0, 1, 'h7C, nv, nb, ld);
        chk(nv == 2, "R4 64-byte page stop", nv, 2);

        // R5 sequential request dropped
        cfg_blen = 4'b0010;
        req_cont = 1;
        fork
            run(0, 0, 1, 'h300, nv, nb, ld);
            begin repeat (6) @(negedge clk); req_cont = 0; end
        join
        chk(nv == 2, "R5 stop on dropped continue", nv, 2);
        chk(nb == 5, "R5 cycles", nb, 5);
        req_cont = 1;

        // R7 write to burst area uses basic cycle
        run(0, 1, 1, 'h310, nv, nb, ld);
        chk(nb == 2 && nv == 0, "R7 write basic cycle", nb, 2);

        // R9 lane select on non-burst 16-bit area
        cfg_burst_en = 2'b01;
        run(1, 0, 0, 'h211, nv, nb, ld);
        chk(nv == 1 && nb == 2, "R7 basic read single access", nb, 2);
        chk(ld == rom_b('h211), "R9 odd byte lane", ld, rom_b('h211));
        run(1, 0, 0, 'h210, nv, nb, ld);
        chk(ld == rom_b('h210), "R9 even byte lane", ld, rom_b('h210));
        cfg_wide = 2'b01;
        run(1, 0, 1, 'h305, nv, nb, ld);
        chk(ld == rom_b('h305), "R9 8-bit zero extend", ld, rom_b('h305));

        // R8 other area's settings changed mid-burst
        cfg_wide = 2'b11; cfg_blen = 4'b0000; cfg_bcyc = 6'b000_001;
        fork
            run(0, 0, 1, 'h100, nv, nb, ld);
            begin repeat (4) @(negedge clk); cfg_blen = 4'b1100; cfg_bcyc = 6'b111_001; cfg_wide = 2'b01; end
        join
        chk(nv == 4 && nb == 9, "R8 area independence", nv, 4);

        // R10 request during busy ignored
        cfg_blen = 4'b0000; cfg_bcyc = 6'b000_001; cfg_wide = 2'b11;
        fork
            run(0, 0, 1, 'h120, nv, nb, ld);
            begin
                repeat (3) @(negedge clk);
                req_valid = 1; req_area = 1; req_addr = AW'('h500);
                @(negedge clk);
                req_valid = 0;
            end
        join
        chk(nv == 4, "R10 busy request ignored words", nv, 4);
        repeat (2) @(negedge clk);
        chk(busy == 0 && ext_cs_n == 2'b11, "R10 no late access", {busy, ext_cs_n}, 3'b011);

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule